// File: doc/BRIEF.md
# Latched-Upper Program Counter

This block holds the byte-addressed program counter of a small processor whose data path is eight bits wide. The counter is 21 bits wide and is split into a low byte, a middle byte (bits 15:8) and an upper field (bits 20:16). Software on the register bus can only reach the low byte directly. The middle and upper parts are changed through two holding latches, which the bus can write and read at any time. The latched values reach the counter only when software writes the low byte, so a computed jump becomes a single commit operation.

Reading the low byte works the other way. It copies the current middle and upper bytes of the counter into the two latches, so software can compute offsets from them. The sequencer advances the counter by one instruction word (two bytes). Jump, call and branch targets load the full counter through a direct-load port. Popped return addresses load it through a separate port. Neither direct load touches the latches. Bit 0 of the counter is always 0.

Top module: `latched_pc`

## Requirements
- R1: Reset (active-low `rst_n`) sets the counter and both holding latches to 0.
- R2: A bus write with `bus_sel`=0 loads the counter with {upper latch, middle latch, write data with bit 0 cleared}, visible on `pc` after the next clock edge.
- R3: `bus_rdata` with `bus_sel`=0 shows `pc[7:0]`. A bus read (`bus_rd`) with `bus_sel`=0 copies `pc[15:8]` into the middle latch and `pc[20:16]` into the upper latch at that edge, and leaves `pc` unchanged.
- R4: A bus write with `bus_sel`=1 sets the middle latch. A bus write with `bus_sel`=2 sets the upper latch from the five low bits of the data. `bus_rdata` shows the middle latch for `bus_sel`=1 and the zero-extended upper latch for `bus_sel`=2. Latch writes leave `pc` unchanged.
- R5: A `step` pulse adds 2 to the counter, wrapping from 0x1FFFFE to 0.
- R6: Bit 0 of `pc` is always 0, including when a target address or write data has bit 0 set.
- R7: `jump_en` loads `jump_addr` (bit 0 cleared) into the counter and leaves both latches unchanged.
- R8: `ret_en` loads `ret_addr` (bit 0 cleared) into the counter and leaves both latches unchanged.
- R9: When several loads occur in one cycle, `jump_en` wins over `ret_en`, `ret_en` wins over a low-byte write, and a low-byte write wins over `step`.
- R10: `bus_sel`=3 reads as 0, and writes to it change neither the counter nor the latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Register select: 0 low byte, 1 middle latch, 2 upper latch, 3 unused |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on low byte) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational on `bus_sel` |
| step | input | 1 | Advance to the next instruction word |
| jump_en | input | 1 | Direct load of a jump, call or branch target |
| jump_addr | input | 21 | Jump, call or branch target |
| ret_en | input | 1 | Load of a popped return address |
| ret_addr | input | 21 | Return address |
| pc | output | 21 | Current program counter |

## Verification
A latch that has taken the wrong value stays hidden until a low-byte write commits it. It then shows up as wrong upper bits of `pc` one cycle after the commit. It can also be read back at once on `bus_rdata` with `bus_sel` 1 or 2. The stimulus therefore reads the latches back after snapshots, jumps and returns, and does not rely only on commits. A wrong priority or step amount shows up on `pc` in the very cycle after the conflicting inputs. The vectors include the wrap at the top of the range and odd target addresses.

// File: rtl/lupc_pkg.sv
package lupc_pkg;

   typedef enum logic [1:0] {
      SEL_LOW  = 2'd0,
      SEL_MID  = 2'd1,
      SEL_UP   = 2'd2,
      SEL_NONE = 2'd3
   } lupc_sel_e;

   typedef enum logic [1:0] {
      SRC_HOLD   = 2'd0,
      SRC_STEP   = 2'd1,
      SRC_COMMIT = 2'd2,
      SRC_LOAD   = 2'd3
   } lupc_src_e;

endpackage

// File: rtl/lupc_latches.sv
module lupc_latches #(
   parameter int BYTE_W = 8,
   parameter int UP_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_mid,
   input  logic              wr_up,
   input  logic              snap,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [BYTE_W-1:0] pc_mid,
   input  logic [UP_W-1:0]   pc_up,
   output logic [BYTE_W-1:0] mid_q,
   output logic [UP_W-1:0]   up_q
);

   initial begin
      if (UP_W < 1 || UP_W >= BYTE_W)
         $error("lupc_latches: UP_W must lie in 1..BYTE_W-1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mid_q <= '0;
         up_q  <= '0;
      end else if (snap) begin
         mid_q <= pc_mid;
         up_q  <= pc_up;
      end else begin
         if (wr_mid) mid_q <= wdata;
         if (wr_up)  up_q  <= wdata[UP_W-1:0];
      end
   end

   // R3: a low-byte read snapshots the upper counter bytes
   assert_snapshot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      snap |=> (mid_q == $past(pc_mid)) && (up_q == $past(pc_up)));

   // R7 R8: without bus access the latches keep their value
   assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_mid || wr_up || snap) |=> $stable(mid_q) && $stable(up_q));

endmodule

// File: rtl/lupc_next.sv
module lupc_next
   import lupc_pkg::*;
#(
   parameter int PC_W       = 21,
   parameter int BYTE_W     = 8,
   parameter int UP_W       = 5,
   parameter int ALIGN_BITS = 1
) (
   input  logic [PC_W-1:0]   pc_q,
   input  logic              step,
   input  logic              commit,
   input  logic [BYTE_W-1:0] low_wdata,
   input  logic [BYTE_W-1:0] mid_q,
   input  logic [UP_W-1:0]   up_q,
   input  logic              jump_en,
   input  logic [PC_W-1:0]   jump_addr,
   input  logic              ret_en,
   input  logic [PC_W-1:0]   ret_addr,
   output logic [PC_W-1:0]   pc_d,
   output logic              pc_load
);

   localparam logic [PC_W-1:0] STEP_INC = {{(PC_W-1){1'b0}}, 1'b1} << ALIGN_BITS;

   lupc_src_e        src;
   logic [PC_W-1:0]  raw;
   logic [PC_W-1:0]  load_val;

   always_comb begin
      load_val = jump_en ? jump_addr : ret_addr;
      if (jump_en || ret_en) src = SRC_LOAD;
      else if (commit)       src = SRC_COMMIT;
      else if (step)         src = SRC_STEP;
      else                   src = SRC_HOLD;
   end

   always_comb begin
      unique case (src)
         SRC_LOAD:   raw = load_val;
         SRC_COMMIT: raw = {up_q, mid_q, low_wdata};
         SRC_STEP:   raw = pc_q + STEP_INC;
         default:    raw = pc_q;
      endcase
   end

   generate
      if (ALIGN_BITS > 0) begin : g_align
         localparam logic [PC_W-1:0] MASK = {{(PC_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};
         assign pc_d = raw & MASK;
      end else begin : g_noalign
         assign pc_d = raw;
      end
   endgenerate

   assign pc_load = (src != SRC_HOLD);

endmodule

// File: rtl/lupc_pc_reg.sv
module lupc_pc_reg #(
   parameter int PC_W       = 21,
   parameter int ALIGN_BITS = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [PC_W-1:0] pc_d,
   output logic [PC_W-1:0] pc_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)    pc_q <= '0;
      else if (load) pc_q <= pc_d;
   end

   generate
      if (ALIGN_BITS > 0) begin : g_chk
         // R6: the counter never leaves word alignment
         assert_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
            pc_q[ALIGN_BITS-1:0] == '0);
      end
   endgenerate

   // R1: the counter is zero after reset
   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> pc_q == '0);

endmodule

// File: rtl/latched_pc.sv
module latched_pc
   import lupc_pkg::*;
#(
   parameter int PC_W       = 21,
   parameter int BYTE_W     = 8,
   parameter int WORD_BYTES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              step,
   input  logic              jump_en,
   input  logic [PC_W-1:0]   jump_addr,
   input  logic              ret_en,
   input  logic [PC_W-1:0]   ret_addr,
   output logic [PC_W-1:0]   pc
);

   localparam int UP_W       = PC_W - 2*BYTE_W;
   localparam int ALIGN_BITS = $clog2(WORD_BYTES);
   localparam logic [PC_W-1:0] ALIGN_MASK = ~((PC_W'(1) << ALIGN_BITS) - PC_W'(1));
   localparam logic [PC_W-1:0] STEP_INC   = PC_W'(1) << ALIGN_BITS;

   initial begin
      if (PC_W <= 2*BYTE_W || PC_W >= 3*BYTE_W)
         $error("latched_pc: PC_W must exceed two bytes and stay below three");
      if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0)
         $error("latched_pc: WORD_BYTES must be a power of two");
   end

   lupc_sel_e         sel;
   logic              wr_low, rd_low, wr_mid, wr_up;
   logic [BYTE_W-1:0] mid_q;
   logic [UP_W-1:0]   up_q;
   logic [PC_W-1:0]   pc_d;
   logic              pc_load;

   assign sel    = lupc_sel_e'(bus_sel);
   assign wr_low = bus_wr && (sel == SEL_LOW);
   assign wr_mid = bus_wr && (sel == SEL_MID);
   assign wr_up  = bus_wr && (sel == SEL_UP);
   assign rd_low = bus_rd && (sel == SEL_LOW);

   always_comb begin
      unique case (sel)
         SEL_LOW: bus_rdata = pc[BYTE_W-1:0];
         SEL_MID: bus_rdata = mid_q;
         SEL_UP:  bus_rdata = {{(BYTE_W-UP_W){1'b0}}, up_q};
         default: bus_rdata = '0;
      endcase
   end

   lupc_latches #(.BYTE_W(BYTE_W), .UP_W(UP_W)) i_latches (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_mid (wr_mid),
      .wr_up  (wr_up),
      .snap   (rd_low),
      .wdata  (bus_wdata),
      .pc_mid (pc[2*BYTE_W-1:BYTE_W]),
      .pc_up  (pc[PC_W-1:2*BYTE_W]),
      .mid_q  (mid_q),
      .up_q   (up_q)
   );

   lupc_next #(.PC_W(PC_W), .BYTE_W(BYTE_W), .UP_W(UP_W), .ALIGN_BITS(ALIGN_BITS)) i_next (
      .pc_q      (pc),
      .step      (step),
      .commit    (wr_low),
      .low_wdata (bus_wdata),
      .mid_q     (mid_q),
      .up_q      (up_q),
      .jump_en   (jump_en),
      .jump_addr (jump_addr),
      .ret_en    (ret_en),
      .ret_addr  (ret_addr),
      .pc_d      (pc_d),
      .pc_load   (pc_load)
   );

   lupc_pc_reg #(.PC_W(PC_W), .ALIGN_BITS(ALIGN_BITS)) i_pc_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (pc_load),
      .pc_d  (pc_d),
      .pc_q  (pc)
   );

   assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !jump_en && !ret_en && !wr_low) |=> pc == $past(pc) + STEP_INC);

   assert_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
      jump_en |=> pc == ($past(jump_addr) & ALIGN_MASK));

   assert_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_en && !jump_en) |=> pc == ($past(ret_addr) & ALIGN_MASK));

   assert_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_low && !jump_en && !ret_en) |=>
         pc == ({$past(up_q), $past(mid_q), $past(bus_wdata)} & ALIGN_MASK));

   assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE && !step && !jump_en && !ret_en) |=> $stable(pc));

endmodule

// File: tb/test_latched_pc.sv
module test_latched_pc;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 15;

   // op: 0 step, 1 write mid latch, 2 write upper latch, 3 write low byte,
   //     4 jump, 5 return, 6 read low byte; then data, then expected pc
   localparam logic [45:0] VEC [NVEC] = '{
      {4'd0, 21'h000000, 21'h000002},
      {4'd0, 21'h000000, 21'h000004},
      {4'd1, 21'h00001A, 21'h000004},
      {4'd2, 21'h000000, 21'h000004},
      {4'd3, 21'h000034, 21'h001A34},
      {4'd0, 21'h000000, 21'h001A36},
      {4'd4, 21'h000D59, 21'h000D58},
      {4'd2, 21'h0000FF, 21'h000D58},
      {4'd3, 21'h000001, 21'h1F1A00},
      {4'd0, 21'h000000, 21'h1F1A02},
      {4'd4, 21'h1FFFFE, 21'h1FFFFE},
      {4'd0, 21'h000000, 21'h000000},
      {4'd5, 21'h012345, 21'h012344},
      {4'd6, 21'h000000, 21'h012344},
      {4'd3, 21'h000010, 21'h012310}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_sel = 2'd0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        step = 1'b0, jump_en = 1'b0, ret_en = 1'b0;
   logic [20:0] jump_addr = '0, ret_addr = '0;
   logic [20:0] pc;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   latched_pc i_latched_pc (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .step(step),
      .jump_en(jump_en), .jump_addr(jump_addr), .ret_en(ret_en), .ret_addr(ret_addr),
      .pc(pc)
   );

   task automatic check(input string tag, input logic [20:0] act, input logic [20:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      bus_wr = 0; bus_rd = 0; step = 0; jump_en = 0; ret_en = 0; bus_sel = 2'd0;
   endtask

   // inputs set at the falling edge, captured at the rising edge, cleared next falling edge
   task automatic apply(input int op, input logic [20:0] data);
      @(negedge clk);
      idle();
      case (op)
         0: step = 1;
         1: begin bus_sel = 2'd1; bus_wr = 1; bus_wdata = data[7:0]; end
         2: begin bus_sel = 2'd2; bus_wr = 1; bus_wdata = data[7:0]; end
         3: begin bus_sel = 2'd0; bus_wr = 1; bus_wdata = data[7:0]; end
         4: begin jump_en = 1; jump_addr = data; end
         5: begin ret_en = 1; ret_addr = data; end
         default: begin bus_sel = 2'd0; bus_rd = 1; end
      endcase
      @(negedge clk);
      idle();
   endtask

   task automatic read_reg(input logic [1:0] s, output logic [7:0] v);
      @(negedge clk);
      idle();
      bus_sel = s;
      #1 v = bus_rdata;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      check("R1 pc after reset", pc, 21'h0);
      read_reg(2'd1, v); check("R1 mid latch after reset", {13'h0, v}, 21'h0);
      read_reg(2'd2, v); check("R1 upper latch after reset", {13'h0, v}, 21'h0);

      // table: R2 R3 R4 R5 R6 R7 R8
      for (int i = 0; i < NVEC; i++) begin
         apply(int'(VEC[i][45:42]), VEC[i][41:21]);
         check($sformatf("R2/R5 vector %0d", i), pc, VEC[i][20:0]);
      end

      // R3: snapshot put 0x23 / 0x01 in the latches; low byte reads pc
      read_reg(2'd1, v); check("R3 mid latch after snapshot", {13'h0, v}, 21'h23);
      read_reg(2'd2, v); check("R3 upper latch after snapshot", {13'h0, v}, 21'h01);
      read_reg(2'd0, v); check("R3 low byte readback", {13'h0, v}, 21'h10);

      // R4: upper latch keeps five bits, latch write leaves pc
      apply(2, 21'h0000EA);
      check("R4 pc unchanged by latch write", pc, 21'h012310);
      read_reg(2'd2, v); check("R4 upper latch 5 bits", {13'h0, v}, 21'h0A);

      // R7: jump leaves latches
      apply(4, 21'h155555);
      check("R6 R7 jump odd target", pc, 21'h155554);
      read_reg(2'd1, v); check("R7 mid latch kept over jump", {13'h0, v}, 21'h23);
      read_reg(2'd2, v); check("R7 upper latch kept over jump", {13'h0, v}, 21'h0A);

      // R8: return leaves latches
      apply(5, 21'h000777);
      check("R8 return load", pc, 21'h000776);
      read_reg(2'd1, v); check("R8 mid latch kept over return", {13'h0, v}, 21'h23);

      // R10: unused select
      @(negedge clk); idle(); bus_sel = 2'd3; bus_wr = 1; bus_wdata = 8'hFF;
      #1 check("R10 unused select reads 0", {13'h0, bus_rdata}, 21'h0);
      @(negedge clk); idle();
      check("R10 pc unchanged", pc, 21'h000776);
      read_reg(2'd1, v); check("R10 mid latch unchanged", {13'h0, v}, 21'h23);
      read_reg(2'd2, v); check("R10 upper latch unchanged", {13'h0, v}, 21'h0A);

      // R9: priorities
      @(negedge clk); idle();
      jump_en = 1; jump_addr = 21'h0ABCD0; ret_en = 1; ret_addr = 21'h111110;
      step = 1; bus_sel = 2'd0; bus_wr = 1; bus_wdata = 8'h44;
      @(negedge clk); idle();
      check("R9 jump wins", pc, 21'h0ABCD0);
      ret_en = 1; ret_addr = 21'h111110; step = 1; bus_wr = 1; bus_wdata = 8'h44;
      @(negedge clk); idle();
      check("R9 return over write", pc, 21'h111110);
      step = 1; bus_wr = 1; bus_wdata = 8'h45;
      @(negedge clk); idle();
      check("R9 R6 write over step", pc, 21'h0A2344);

      // R1: reset mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      check("R1 pc after second reset", pc, 21'h0);
      read_reg(2'd1, v); check("R1 mid latch after second reset", {13'h0, v}, 21'h0);
      read_reg(2'd2, v); check("R1 upper latch after second reset", {13'h0, v}, 21'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule